// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block watches the two inputs of a PLL phase detector, the reference edge stream and the divided feedback edge stream, and reports whether the loop is locked. Both inputs are brought into a fast sampling clock domain. For every reference cycle the block counts, in sampling ticks, how far apart the rising edges of the reference and the feedback are. The block accepts either edge arriving first.

A reference cycle passes when that skew is below a window set by a parameter. The single lock flag rises only after a run of consecutive passing reference cycles. One failing cycle clears the run and drops the flag at once, with no averaging and no hysteresis. The flag feeds synthesiser control, for example to end a fast-acquisition mode or to gate a lock-dependent output.

Top module: `pll_lock_detect`

## Requirements
- R1: Each input passes through a two-stage synchroniser, and only its rising edges are used. Equal skew at the two input pins gives equal skew in sampling ticks, and a skew of 0 ticks counts as a pass.
- R2: The skew is the number of sampling ticks between the reference rising edge and the feedback rising edge, whichever arrives first. A cycle passes when the skew is strictly below WINDOW_TICKS (default 3). A skew of 2 passes in either direction, and a skew of 3 fails in either direction.
- R3: If the reference leads and no feedback edge arrives within WINDOW_TICKS ticks, the cycle fails. A missing feedback edge and a feedback edge that arrives late both fail.
- R4: Cycles are counted on the reference only. Each reference rising edge produces exactly one verdict. A feedback pulse with no reference edge near it neither advances nor clears the run of passes.
- R5: lock_o rises only after PASS_COUNT consecutive passing reference cycles (default 5). It stays low after PASS_COUNT-1 passes.
- R6: A single failing reference cycle clears the pass run to zero and drives lock_o low. After that, a full run of PASS_COUNT passes is needed to lock again.
- R7: While the loop is locked, further passes keep lock_o high. The pass run saturates at PASS_COUNT and does not wrap.
- R8: While rst_ni is low, lock_o is 0, the pass run is 0 and the skew measurement is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference edge stream, asynchronous |
| fb_i | input | 1 | Divided feedback edge stream, asynchronous |
| lock_o | output | 1 | High while the loop is judged locked |

## Verification
lock_o is the only port that shows internal state, so each fault must be found through it. A pass run that is off by one, or one that wraps instead of saturating, makes lock_o rise one reference cycle too early or too late. It can also make lock_o fail to return after a single fault. A skew counter or window compare that is off by one tick turns the 2-tick and 3-tick cases into the wrong verdict. A feedback edge wrongly counted as a reference cycle makes lock_o rise one cycle early. Every such fault shows within one reference cycle of the stimulus that exposes it, about four sampling ticks after the second edge.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;

  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_REF_LEAD = 2'd1,
    MS_FB_LEAD  = 2'd2
  } meas_state_e;

  typedef struct packed {
    logic valid;
    logic pass;
  } verdict_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r1_rise_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/skew_meter.sv
module skew_meter
  import lock_det_pkg::*;
#(
  parameter int WINDOW_TICKS = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ref_rise_i,
  input  logic     fb_rise_i,
  output verdict_t verdict_o
);

  localparam int CW = (WINDOW_TICKS < 2) ? 1 : $clog2(WINDOW_TICKS + 1);
  localparam logic [CW:0] WIN = (CW+1)'(WINDOW_TICKS);

  meas_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   elapsed;
  verdict_t      vd_d, verdict_q;

  assign elapsed = {1'b0, cnt_q} + (CW+1)'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    vd_d    = '0;
    unique case (state_q)
      MS_IDLE: begin
        if (ref_rise_i && fb_rise_i) begin
          vd_d = '{valid: 1'b1, pass: 1'b1};
        end else if (ref_rise_i) begin
          state_d = MS_REF_LEAD;
          cnt_d   = '0;
        end else if (fb_rise_i) begin
          state_d = MS_FB_LEAD;
          cnt_d   = '0;
        end
      end
      MS_REF_LEAD: begin
        if (fb_rise_i) begin
          vd_d    = '{valid: 1'b1, pass: (elapsed < WIN)};
          state_d = ref_rise_i ? MS_REF_LEAD : MS_IDLE;
          cnt_d   = '0;
        end else if (ref_rise_i) begin
          // new reference before feedback: previous cycle failed
          vd_d    = '{valid: 1'b1, pass: 1'b0};
          cnt_d   = '0;
        end else if (elapsed >= WIN) begin
          vd_d    = '{valid: 1'b1, pass: 1'b0};
          state_d = MS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d   = elapsed[CW-1:0];
        end
      end
      MS_FB_LEAD: begin
        if (ref_rise_i) begin
          vd_d    = '{valid: 1'b1, pass: (elapsed < WIN)};
          state_d = fb_rise_i ? MS_FB_LEAD : MS_IDLE;
          cnt_d   = '0;
        end else if (fb_rise_i) begin
          cnt_d   = '0;
        end else if (elapsed >= WIN) begin
          // feedback too early: the coming reference is judged on its own
          state_d = MS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d   = elapsed[CW-1:0];
        end
      end
      default: begin
        state_d = MS_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= MS_IDLE;
      cnt_q     <= '0;
      verdict_q <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      verdict_q <= vd_d;
    end
  end

  assign verdict_o = verdict_q;

  a_r2_cnt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < WIN));

  a_r3_timeout_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_REF_LEAD && !fb_rise_i && !ref_rise_i && elapsed == WIN)
      |=> (verdict_q.valid && !verdict_q.pass));

  a_r4_ref_gives_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_FB_LEAD && ref_rise_i) |=> verdict_q.valid);

  a_r4_fb_alone_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_IDLE && fb_rise_i && !ref_rise_i) |=> !verdict_q.valid);

endmodule

// File: rtl/pass_qualifier.sv
module pass_qualifier
  import lock_det_pkg::*;
#(
  parameter int PASS_COUNT = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  verdict_t verdict_i,
  output logic     lock_o
);

  localparam int PW = (PASS_COUNT < 2) ? 1 : $clog2(PASS_COUNT + 1);
  localparam logic [PW-1:0] FULL = PW'(PASS_COUNT);

  logic [PW-1:0] run_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (verdict_i.valid) begin
      if (verdict_i.pass) begin
        if (run_q != FULL) run_q <= run_q + PW'(1);
        lock_q <= (run_q >= FULL - PW'(1));
      end else begin
        run_q  <= '0;
        lock_q <= 1'b0;
      end
    end
  end

  assign lock_o = lock_q;

  a_r5_rise_on_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(verdict_i.valid && verdict_i.pass));

  a_r5_lock_needs_full_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> (run_q == FULL));

  a_r6_fail_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_i.valid && !verdict_i.pass) |=> (!lock_q && run_q == '0));

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= FULL);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !(verdict_i.valid && !verdict_i.pass)) |=> lock_q);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import lock_det_pkg::*;
#(
  parameter int WINDOW_TICKS = 3,
  parameter int PASS_COUNT   = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic lock_o
);

  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise;
  verdict_t        verdict;

  assign raw_in = {fb_i, ref_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in[g]),
      .rise_o (rise[g])
    );
  end

  skew_meter #(.WINDOW_TICKS(WINDOW_TICKS)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (rise[0]),
    .fb_rise_i  (rise[1]),
    .verdict_o  (verdict)
  );

  pass_qualifier #(.PASS_COUNT(PASS_COUNT)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .verdict_i (verdict),
    .lock_o    (lock_o)
  );

  a_r8_reset_unlocked: assert property (@(posedge clk_i)
    !rst_ni |=> !lock_o);

endmodule

// File: tb/sim_pll_lock_detect.sv
module sim_pll_lock_detect;

  localparam int WIN    = 3;
  localparam int NPASS  = 5;
  localparam int PERIOD = 24;
  localparam int BASE   = 4;
  localparam int HIGH   = 12;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_i = 1'b0;
  logic fb_i = 1'b0;
  logic lock_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m_run = 0;
  bit m_lock = 1'b0;
  item_t q[$];
  event ev_chk;

  always #4 clk = ~clk;

  pll_lock_detect u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .ref_i  (ref_i),
    .fb_i   (fb_i),
    .lock_o (lock_o)
  );

  // skew > 0: reference leads; skew < 0: feedback leads
  task automatic run_cycle(input int skew, input bit has_ref, input bit has_fb, input string tag);
    int a_ref = BASE;
    int a_fb = BASE;
    item_t it;
    if (skew >= 0) a_fb = BASE + skew;
    else           a_ref = BASE - skew;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      ref_i = has_ref && (i >= a_ref) && (i < a_ref + HIGH);
      fb_i  = has_fb  && (i >= a_fb)  && (i < a_fb + HIGH);
    end
    @(negedge clk);
    ref_i = 1'b0;
    fb_i  = 1'b0;
    if (has_ref) begin
      if (has_fb && skew < WIN && skew > -WIN) begin
        if (m_run < NPASS) m_run++;
        m_lock = (m_run >= NPASS);
      end else begin
        m_run  = 0;
        m_lock = 1'b0;
      end
    end
    it.exp = m_lock;
    it.tag = tag;
    q.push_back(it);
    ->ev_chk;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (lock_o !== it.exp) begin
          n_bad++;
          $display("FAIL %s: lock_o=%b expected %b at %0t", it.tag, lock_o, it.exp, $time);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    n_cmp++;
    if (lock_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: lock_o=%b in reset, expected 0", lock_o);
    end
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1, R2: passes in both directions, no lock before the full run (R5)
    run_cycle(0, 1, 1, "R1");
    run_cycle(1, 1, 1, "R2");
    run_cycle(-1, 1, 1, "R2");
    run_cycle(2, 1, 1, "R5");
    run_cycle(-2, 1, 1, "R5");
    // R7: remain locked
    run_cycle(0, 1, 1, "R7");
    run_cycle(2, 1, 1, "R7");
    run_cycle(-1, 1, 1, "R7");
    // R2 boundary: skew 3 fails, R6 drop
    run_cycle(3, 1, 1, "R6");
    for (int k = 0; k < NPASS - 1; k++) run_cycle(1, 1, 1, "R6");
    run_cycle(0, 1, 1, "R6");
    // R3: missing feedback
    run_cycle(0, 1, 0, "R3");
    // R4: feedback-only pulse does not count
    for (int k = 0; k < NPASS - 1; k++) run_cycle(0, 1, 1, "R4");
    run_cycle(0, 0, 1, "R4");
    run_cycle(1, 1, 1, "R4");
    // R2: feedback leading by 3 fails
    run_cycle(-3, 1, 1, "R2");
    for (int k = 0; k < NPASS; k++) run_cycle(-2, 1, 1, "R5");
    // R3: late feedback
    run_cycle(6, 1, 1, "R3");
    for (int k = 0; k < NPASS; k++) run_cycle(0, 1, 1, "R5");
    // R8: reset while locked
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    n_cmp++;
    if (lock_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: lock_o=%b after reset, expected 0", lock_o);
    end
    rst_ni = 1'b1;
    m_run  = 0;
    m_lock = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < NPASS - 1; k++) run_cycle(0, 1, 1, "R8");
    run_cycle(1, 1, 1, "R8");
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule